// File: doc/BRIEF.md
# Keyed Register-Write Lock Controller

This block guards a small bank of pin-function selection registers. Software must write a 16-bit unlock key before any selection register accepts a write. A correct key opens a write window. The window stays open as long as accesses to the bank keep arriving close together. It closes by itself once a fixed number of cycles pass with no such access. The selection registers drive a flat pin-select bus that the surrounding multiplexing logic decodes.

A permit bit in the control register decides what happens after the window closes. With the bit clear, the bank can be unlocked only once per reset, and every later key write is ignored. With the bit set, each later correct key opens a fresh window. A state machine with three states tracks this:

- `ST_ARMED`: locked, and a key may unlock it.
- `ST_OPEN`: the write window is open.
- `ST_SEALED`: locked until reset.

The machine has these transitions:

- ARMED to OPEN on a correct key.
- OPEN to OPEN on any access that reloads the timer.
- OPEN to ARMED on timeout or on a wrong key, when permit is set.
- OPEN to SEALED on the same events, when permit is clear.
- SEALED to SEALED always.

Address map:

| Address | Register |
|---|---|
| 0 | Key |
| 1 | Control |
| 2 + i | Selection register i |

Top module: `keylock_ctrl`

## Requirements
- R1: After reset the block is in ST_ARMED with the window closed and the permit bit at 0. Selection register i holds the value i.
- R2: A write of 0x2D52 to address 0 in ST_ARMED opens the window from the next cycle. A write of any other value to address 0 leaves the window closed.
- R3: An access sampled k cycles after the previous reloading access (or after the opening key) is accepted for k from 1 to 31. At k = 32 the window has already closed, and a selection write is ignored.
- R4: While the window is open, each of the following reloads the idle timer: a read or write of a selection register, a write of the control register, and a correct key write.
- R5: While the window is closed, writes to selection registers and to the control register have no effect.
- R6: If the window closes while the permit bit is 0, the block enters ST_SEALED. Every later key write, correct or not, is ignored until reset.
- R7: If the window closes while the permit bit is 1, a later correct key opens a new window.
- R8: A wrong key written while the window is open closes it on that edge. A selection write on the following cycle is ignored.
- R9: Reading address 0 returns the fixed signature 0xA5C3 and never the key. Reading address 1 returns the permit bit at bit 0 and a locked flag at bit 1 (1 = window closed), with the other bits 0. When read enable is low, read data is 0.
- R10: The pin-select output always carries selection register i in bits [i*6 +: 6]. A selection register read returns the same value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Combinational read data |
| pin_sel | output | 24 | Concatenated selection register contents |

## Verification
On every cycle, the assertions check the following:

- The window can only open in the cycle after a correct key.
- The sealed state never leaves, and the window never reopens from it.
- A wrong key in an open window closes it.
- The idle count stays below its limit while open.
- The pin-select bus holds still while the window is closed.
- Key reads return the signature.

The exact cycle boundary of the timeout (31 accepted, 32 refused), the reload by each kind of access, and the one-shot versus repeatable unlock can only be shown by the bench's timed scenarios. The bench covers these by sweeping the gap after the key across every value from 1 to 34.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_OPEN   = 2'd1,
        ST_SEALED = 2'd2
    } lock_state_e;

endpackage

// File: rtl/keylock_idle_timer.sv
module keylock_idle_timer #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_open,
    input  logic touch,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT);
    localparam int LIMIT = TIMEOUT - 2;

    logic [CNT_W-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (!win_open || touch) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // Closing on the edge with count LIMIT means an access k = TIMEOUT-1
    // cycles later still lands, and k = TIMEOUT finds the window shut.
    always_comb begin
        expire = win_open && !touch && (idle_q == CNT_W'(LIMIT));
    end

    a_r3_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (idle_q <= CNT_W'(LIMIT)));

endmodule

// File: rtl/keylock_seq.sv
module keylock_seq
    import keylock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_good,
    input  logic key_bad,
    input  logic expire,
    input  logic permit,
    output logic win_open
);
    lock_state_e state_q;
    lock_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (key_good) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (key_bad || expire) state_d = permit ? ST_ARMED : ST_SEALED;
            end
            ST_SEALED: begin
                state_d = ST_SEALED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        win_open = (state_q == ST_OPEN);
    end

    a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !$past(win_open)) |-> $past(key_good));

    a_r6_sealed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEALED) |=> (state_q == ST_SEALED) && !win_open);

    a_r8_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && key_bad) |=> !win_open);

endmodule

// File: rtl/keylock_map_bank.sv
module keylock_map_bank #(
    parameter int N_MAPS = 4,
    parameter int MAP_W  = 6,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [MAP_W-1:0]        wr_val,
    output logic [N_MAPS*MAP_W-1:0] regs_flat
);
    for (genvar g = 0; g < N_MAPS; g++) begin : g_map
        logic [MAP_W-1:0] sel_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q <= MAP_W'(g);
            end else if (wr_stb && (wr_idx == IDX_W'(g))) begin
                sel_q <= wr_val;
            end
        end

        assign regs_flat[g*MAP_W +: MAP_W] = sel_q;
    end

endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl #(
    parameter int          N_MAPS  = 4,
    parameter int          MAP_W   = 6,
    parameter int          DATA_W  = 16,
    parameter int          ADDR_W  = 4,
    parameter int          TIMEOUT = 32,
    parameter logic [15:0] KEY_VAL = 16'h2D52,
    parameter logic [15:0] SIG_VAL = 16'hA5C3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    rd_en,
    output logic [DATA_W-1:0]       rd_data,
    output logic [N_MAPS*MAP_W-1:0] pin_sel
);
    localparam int IDX_W    = (N_MAPS > 1) ? $clog2(N_MAPS) : 1;
    localparam int KEY_ADR  = 0;
    localparam int CTL_ADR  = 1;
    localparam int MAP_BASE = 2;

    logic              is_key, is_ctl, is_map;
    logic [ADDR_W-1:0] addr_off;
    logic [IDX_W-1:0]  map_idx;
    logic              key_good, key_bad, touch, expire, win_open;
    logic              permit_q;

    always_comb begin
        addr_off = addr - ADDR_W'(MAP_BASE);
        is_key   = (addr == ADDR_W'(KEY_ADR));
        is_ctl   = (addr == ADDR_W'(CTL_ADR));
        is_map   = (addr >= ADDR_W'(MAP_BASE)) && (addr_off < ADDR_W'(N_MAPS));
        map_idx  = IDX_W'(addr_off);
        key_good = wr_en && is_key && (wr_data == DATA_W'(KEY_VAL));
        key_bad  = wr_en && is_key && (wr_data != DATA_W'(KEY_VAL));
        touch    = win_open && ((wr_en && (is_map || is_ctl)) || key_good
                                || (rd_en && is_map));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            permit_q <= 1'b0;
        end else if (win_open && wr_en && is_ctl) begin
            permit_q <= wr_data[0];
        end
    end

    keylock_idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_open (win_open),
        .touch    (touch),
        .expire   (expire)
    );

    keylock_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_good (key_good),
        .key_bad  (key_bad),
        .expire   (expire),
        .permit   (permit_q),
        .win_open (win_open)
    );

    keylock_map_bank #(.N_MAPS(N_MAPS), .MAP_W(MAP_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (win_open && wr_en && is_map),
        .wr_idx    (map_idx),
        .wr_val    (wr_data[MAP_W-1:0]),
        .regs_flat (pin_sel)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (is_key) begin
                rd_data = DATA_W'(SIG_VAL);
            end else if (is_ctl) begin
                rd_data = DATA_W'({!win_open, permit_q});
            end else if (is_map) begin
                for (int i = 0; i < N_MAPS; i++) begin
                    if (map_idx == IDX_W'(i)) rd_data = DATA_W'(pin_sel[i*MAP_W +: MAP_W]);
                end
            end
        end
    end

    a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(pin_sel));

    a_r9_signature: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_key) |-> (rd_data == DATA_W'(SIG_VAL)));

endmodule

// File: tb/tb_keylock_ctrl.sv
`timescale 1ns/1ps
module tb_keylock_ctrl;
    localparam int N = 4;
    localparam int W = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        wr_en, rd_en;
    logic [15:0] wr_data, rd_data;
    logic [23:0] pin_sel;

    int total = 0;
    int bad = 0;
    logic [W-1:0] exp_map [N];

    always #4 clk = ~clk;

    keylock_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_sel(pin_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] packed_exp();
        logic [23:0] p;
        for (int i = 0; i < N; i++) p[i*W +: W] = exp_map[i];
        return p;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; addr = '0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        idle(3);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) exp_map[i] = W'(i);
        idle(1);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        do_reset();
        // R1 R10 R9: reset contents and reads
        chk("R1 pin_sel default", pin_sel, packed_exp());
        do_rd(4'd1, d); chk("R1 ctrl locked permit0", d, 16'h0002);
        do_rd(4'd0, d); chk("R9 key signature", d, 16'hA5C3);
        do_rd(4'd4, d); chk("R10 map2 read", d, 16'd2);
        #1 chk("R9 idle read zero", rd_data, 16'h0000);

        // R2 R5: wrong key leaves it shut, writes ignored
        do_wr(4'd0, 16'h2D53);
        do_wr(4'd2, 16'h003F);
        chk("R2 R5 wrong key no write", pin_sel, packed_exp());
        do_wr(4'd1, 16'h0001);
        do_rd(4'd1, d); chk("R5 ctrl write while locked", d, 16'h0002);

        // R2 R10: open, write every map, read back
        do_wr(4'd0, 16'h2D52);
        do_rd(4'd1, d); chk("R2 window open", d, 16'h0000);
        for (int i = 0; i < N; i++) begin
            exp_map[i] = W'(i * 13 + 5);
            do_wr(4'(2 + i), 16'(i * 13 + 5));
        end
        chk("R10 pin_sel after writes", pin_sel, packed_exp());
        for (int i = 0; i < N; i++) begin
            do_rd(4'(2 + i), d); chk("R10 map readback", d, 16'(exp_map[i]));
        end
        do_wr(4'd1, 16'h0001);
        do_rd(4'd1, d); chk("R9 permit set", d, 16'h0001);
        idle(40);
        do_rd(4'd1, d); chk("R3 closed after idle", d, 16'h0003);

        // R3 R7: sweep the gap between key and write
        for (int k = 1; k <= 34; k++) begin
            do_wr(4'd0, 16'h2D52);
            idle(k - 1);
            do_wr(4'd2, 16'(k));
            if (k <= 31) exp_map[0] = W'(k);
            chk("R3 R7 gap sweep", pin_sel, packed_exp());
            idle(40);
        end

        // R4: chain of writes at gap 31
        do_wr(4'd0, 16'h2D52);
        for (int j = 0; j < 5; j++) begin
            idle(30);
            do_wr(4'd3, 16'(40 + j));
            exp_map[1] = W'(40 + j);
            chk("R4 write chain reload", pin_sel, packed_exp());
        end
        idle(40);
        do_wr(4'd0, 16'h2D52);
        idle(19); do_rd(4'd4, d);
        idle(19); do_wr(4'd4, 16'd21); exp_map[2] = 6'd21;
        chk("R4 read reload", pin_sel, packed_exp());
        idle(40);
        do_wr(4'd0, 16'h2D52);
        idle(19); do_wr(4'd1, 16'h0001);
        idle(19); do_wr(4'd5, 16'd22); exp_map[3] = 6'd22;
        chk("R4 ctrl write reload", pin_sel, packed_exp());
        idle(40);
        do_wr(4'd0, 16'h2D52);
        idle(19); do_wr(4'd0, 16'h2D52);
        idle(19); do_wr(4'd2, 16'd23); exp_map[0] = 6'd23;
        chk("R4 key reload", pin_sel, packed_exp());
        idle(40);

        // R8 R7: wrong key closes, permit allows reopen
        do_wr(4'd0, 16'h2D52);
        do_wr(4'd0, 16'h1234);
        do_wr(4'd3, 16'd9);
        chk("R8 write after bad key", pin_sel, packed_exp());
        do_rd(4'd1, d); chk("R8 locked permit kept", d, 16'h0003);
        do_wr(4'd0, 16'h2D52);
        do_wr(4'd3, 16'd9); exp_map[1] = 6'd9;
        chk("R7 reopen with permit", pin_sel, packed_exp());

        // R6: one-shot unlock on timeout
        do_reset();
        do_wr(4'd0, 16'h2D52);
        do_wr(4'd2, 16'd5); exp_map[0] = 6'd5;
        idle(40);
        do_wr(4'd0, 16'h2D52);
        do_wr(4'd2, 16'd9);
        chk("R6 sealed after timeout", pin_sel, packed_exp());
        do_rd(4'd1, d); chk("R6 still locked", d, 16'h0002);

        // R6 R8: wrong key with permit clear seals
        do_reset();
        do_wr(4'd0, 16'h2D52);
        do_wr(4'd0, 16'h0000);
        do_wr(4'd0, 16'h2D52);
        do_wr(4'd3, 16'd33);
        chk("R6 R8 sealed after bad key", pin_sel, packed_exp());

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule